// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Stage Tracker

This block follows a control transfer on the default endpoint. It does not look at bits on the wire. It works from events that the packet layer has already decoded: a SETUP packet arrived (with its eight bytes), an IN token was served, or an OUT token was received (with its payload length). The eight SETUP bytes give the data direction and the declared length. The tracker then moves through a data stage, a status stage and completion. It recognises the status stage only when the token direction turns around.

While the data stage runs, the tracker adds up the bytes moved. It enters a stall state in three cases: the running total would exceed the declared length, the request decoder reports a request it rejects, or a token in the data direction arrives during the status stage. In an OUT-direction transfer, the tracker asks for a zero-length IN packet once the decoder has accepted the command. Completion gives a one-cycle pulse. A fresh SETUP or a bus reset restarts the tracker from any state.

Top module: `ctl_xfer_tracker`

## Requirements
- R1: While rst_n is low, and in the cycle after a cycle with usb_reset high, stage reads 0 (idle) and stall, status_phase, zlp_req and xfer_done are all low.
- R2: Byte k of the SETUP packet sits at setup_pkt[8k+7:8k]. Bit 7 of byte 0 gives the direction (1 = device to host). The declared length is byte 6 (low) together with byte 7 (high). After a SETUP with a non-zero length, stage is 2 (data IN) when the direction bit is 1, and 1 (data OUT) when it is 0.
- R3: A SETUP that declares length 0 moves stage straight to 3 (status IN), whatever the direction bit.
- R4: In stage 1, the first IN token moves stage to 3 and raises status_phase.
- R5: In stage 2, the first OUT token moves stage to 4 (status OUT) and raises status_phase.
- R6: zlp_req is high exactly when stage is 3 and a dec_strobe with dec_ok high has been seen since the last SETUP.
- R7: In stage 3 an IN token, or in stage 4 an OUT token, completes the transfer once the command has been accepted. xfer_done is then high for one cycle and stage returns to 0. Before acceptance, such a token leaves the stage unchanged.
- R8: In a data stage, a token in the data direction whose tok_len would take the running byte total above the declared length moves stage to 5 (stall). Reaching the declared length exactly is allowed.
- R9: dec_strobe with dec_ok low, in any stage from 1 to 4, moves stage to 5.
- R10: In stage 3 an OUT token, and in stage 4 an IN token, move stage to 5.
- R11: In stage 5, stall is high. Tokens and decoder strobes have no effect. Only a SETUP or usb_reset leaves stage 5.
- R12: A SETUP in any stage starts a new transfer. It clears the byte total, the acceptance flag and any stall.
- R13: Priority within one cycle is usb_reset, then SETUP, then a decoder reject, then tokens. When tok_in and tok_out are both high, only tok_in is taken. In stage 0, tokens and decoder strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_reset | input | 1 | Bus reset seen; returns tracker to idle |
| setup_evt | input | 1 | One-cycle pulse: SETUP packet received |
| setup_pkt | input | 64 | The eight SETUP bytes, byte 0 in the low bits |
| tok_in | input | 1 | One-cycle pulse: IN token served on endpoint zero |
| tok_out | input | 1 | One-cycle pulse: OUT token received on endpoint zero |
| tok_len | input | PKT_LEN_W | Payload bytes of the token's data packet |
| dec_strobe | input | 1 | Request decoder verdict valid |
| dec_ok | input | 1 | Verdict: 1 = request accepted, 0 = rejected |
| stage | output | 3 | 0 idle, 1 data OUT, 2 data IN, 3 status IN, 4 status OUT, 5 stall |
| status_phase | output | 1 | Stage is 3 or 4 |
| zlp_req | output | 1 | Send a zero-length IN packet for the status stage |
| stall | output | 1 | Endpoint zero answers with a stall handshake |
| xfer_done | output | 1 | One-cycle pulse on completion of the status stage |

## Verification
The hardest case to reach is the overrun boundary. The running total must land exactly on the declared length and be accepted, while one byte more, in a later packet, stalls. The stimulus declares a length whose high and low bytes differ, so that a byte-order slip shows up. It then sends several full packets and a final partial one that ends exactly on the limit, and repeats the case with a short limit that a second packet goes past. Random traffic runs after the directed cases. It mixes simultaneous tokens, late decoder verdicts and SETUPs in the middle of a transfer against the reference model.

// File: rtl/ctl_trk_pkg.sv
package ctl_trk_pkg;

    localparam int SETUP_BYTES = 8;
    localparam int SETUP_W     = SETUP_BYTES * 8;
    localparam int WLEN_W      = 16;
    localparam int CNT_W       = WLEN_W + 1;

    typedef enum logic [2:0] {
        STG_IDLE     = 3'd0,
        STG_DATA_OUT = 3'd1,
        STG_DATA_IN  = 3'd2,
        STG_STAT_IN  = 3'd3,
        STG_STAT_OUT = 3'd4,
        STG_STALL    = 3'd5
    } stage_e;

    typedef struct packed {
        stage_e              stage;
        logic                to_host;
        logic [WLEN_W-1:0]   wlen;
        logic [CNT_W-1:0]    cnt;
        logic                cmd_ok;
        logic                done;
    } trk_state_t;

endpackage

// File: rtl/ctl_setup_fields.sv
module ctl_setup_fields
    import ctl_trk_pkg::*;
(
    input  logic [SETUP_W-1:0] pkt_i,
    output logic               to_host_o,
    output logic [WLEN_W-1:0]  wlen_o,
    output logic               zero_len_o
);

    logic [7:0] byte_q [SETUP_BYTES];

    for (genvar k = 0; k < SETUP_BYTES; k++) begin : g_split
        assign byte_q[k] = pkt_i[8*k +: 8];
    end

    // Direction is the top bit of the request-type byte; length is bytes 6/7, low first.
    assign to_host_o  = byte_q[0][7];
    assign wlen_o     = {byte_q[7], byte_q[6]};
    assign zero_len_o = (wlen_o == '0);

    logic unused_fields;
    assign unused_fields = ^{byte_q[0][6:0], byte_q[1], byte_q[2],
                             byte_q[3], byte_q[4], byte_q[5]};

endmodule

// File: rtl/ctl_len_guard.sv
module ctl_len_guard #(
    parameter int LIM_W = 16,
    parameter int PKT_W = 7
) (
    input  logic [LIM_W:0]   cnt_i,
    input  logic [PKT_W-1:0] len_i,
    input  logic [LIM_W-1:0] lim_i,
    output logic [LIM_W:0]   sum_o,
    output logic             over_o
);

    localparam int PAD_W = LIM_W + 1 - PKT_W;

    assign sum_o  = cnt_i + {{PAD_W{1'b0}}, len_i};
    assign over_o = (sum_o > {1'b0, lim_i});

endmodule

// File: rtl/ctl_xfer_tracker.sv
module ctl_xfer_tracker
    import ctl_trk_pkg::*;
#(
    parameter int PKT_LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 usb_reset,
    input  logic                 setup_evt,
    input  logic [SETUP_W-1:0]   setup_pkt,
    input  logic                 tok_in,
    input  logic                 tok_out,
    input  logic [PKT_LEN_W-1:0] tok_len,
    input  logic                 dec_strobe,
    input  logic                 dec_ok,
    output logic [2:0]           stage,
    output logic                 status_phase,
    output logic                 zlp_req,
    output logic                 stall,
    output logic                 xfer_done
);

    localparam trk_state_t RESET_STATE = '0;

    trk_state_t st_q, st_d;

    logic              su_to_host;
    logic [WLEN_W-1:0] su_wlen;
    logic              su_zero;
    logic [CNT_W-1:0]  sum;
    logic              over;

    ctl_setup_fields u_fields (
        .pkt_i      (setup_pkt),
        .to_host_o  (su_to_host),
        .wlen_o     (su_wlen),
        .zero_len_o (su_zero)
    );

    ctl_len_guard #(
        .LIM_W (WLEN_W),
        .PKT_W (PKT_LEN_W)
    ) u_guard (
        .cnt_i  (st_q.cnt),
        .len_i  (tok_len),
        .lim_i  (st_q.wlen),
        .sum_o  (sum),
        .over_o (over)
    );

    logic active;
    logic t_in;
    logic t_out;

    assign active = (st_q.stage != STG_IDLE) && (st_q.stage != STG_STALL);
    assign t_in   = tok_in;
    assign t_out  = tok_out & ~tok_in;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (usb_reset) begin
            st_d = RESET_STATE;
        end else if (setup_evt) begin
            st_d.to_host = su_to_host;
            st_d.wlen    = su_wlen;
            st_d.cnt     = '0;
            st_d.cmd_ok  = 1'b0;
            if (su_zero)
                st_d.stage = STG_STAT_IN;
            else if (su_to_host)
                st_d.stage = STG_DATA_IN;
            else
                st_d.stage = STG_DATA_OUT;
        end else if (active && dec_strobe && !dec_ok) begin
            st_d.stage = STG_STALL;
        end else begin
            if (active && dec_strobe && dec_ok)
                st_d.cmd_ok = 1'b1;
            unique case (st_q.stage)
                STG_DATA_OUT: begin
                    if (t_in) begin
                        st_d.stage = STG_STAT_IN;
                    end else if (t_out) begin
                        if (over) st_d.stage = STG_STALL;
                        else      st_d.cnt   = sum;
                    end
                end
                STG_DATA_IN: begin
                    if (t_out) begin
                        st_d.stage = STG_STAT_OUT;
                    end else if (t_in) begin
                        if (over) st_d.stage = STG_STALL;
                        else      st_d.cnt   = sum;
                    end
                end
                STG_STAT_IN: begin
                    if (t_out) begin
                        st_d.stage = STG_STALL;
                    end else if (t_in && st_q.cmd_ok) begin
                        st_d.stage = STG_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
                STG_STAT_OUT: begin
                    if (t_in) begin
                        st_d.stage = STG_STALL;
                    end else if (t_out && st_q.cmd_ok) begin
                        st_d.stage = STG_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign stage        = st_q.stage;
    assign status_phase = (st_q.stage == STG_STAT_IN) || (st_q.stage == STG_STAT_OUT);
    assign zlp_req      = (st_q.stage == STG_STAT_IN) && st_q.cmd_ok;
    assign stall        = (st_q.stage == STG_STALL);
    assign xfer_done    = st_q.done;

endmodule

// File: rtl/ctl_xfer_tracker_chk.sv
module ctl_xfer_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        usb_reset,
    input logic        setup_evt,
    input logic [63:0] setup_pkt,
    input logic [2:0]  stage,
    input logic        stall,
    input logic        zlp_req,
    input logic        xfer_done
);

    a_r1_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> (stage == 3'd0));

    a_r2_dir_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_evt && !usb_reset && setup_pkt[7] && setup_pkt[63:48] != 16'd0)
        |=> (stage == 3'd2));

    a_r3_zero_len_status: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_evt && !usb_reset && setup_pkt[63:48] == 16'd0) |=> (stage == 3'd3));

    a_r6_zlp_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_req |-> (stage == 3'd3));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (stage == 3'd0));

    a_r11_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !setup_evt && !usb_reset) |=> stall);

    a_r12_setup_unstalls: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_evt && !usb_reset) |=> !stall);

endmodule

bind ctl_xfer_tracker ctl_xfer_tracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .usb_reset (usb_reset),
    .setup_evt (setup_evt),
    .setup_pkt (setup_pkt),
    .stage     (stage),
    .stall     (stall),
    .zlp_req   (zlp_req),
    .xfer_done (xfer_done)
);

// File: tb/ctl_xfer_tracker_bench.sv
module ctl_xfer_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PLW        = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           usb_reset = 1'b0;
    logic           setup_evt = 1'b0;
    logic [63:0]    setup_pkt = '0;
    logic           tok_in = 1'b0;
    logic           tok_out = 1'b0;
    logic [PLW-1:0] tok_len = '0;
    logic           dec_strobe = 1'b0;
    logic           dec_ok = 1'b0;
    logic [2:0]     stage;
    logic           status_phase;
    logic           zlp_req;
    logic           stall;
    logic           xfer_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_xfer_tracker #(.PKT_LEN_W(PLW)) u_ctl_xfer_tracker (
        .clk(clk), .rst_n(rst_n), .usb_reset(usb_reset), .setup_evt(setup_evt),
        .setup_pkt(setup_pkt), .tok_in(tok_in), .tok_out(tok_out), .tok_len(tok_len),
        .dec_strobe(dec_strobe), .dec_ok(dec_ok), .stage(stage),
        .status_phase(status_phase), .zlp_req(zlp_req), .stall(stall),
        .xfer_done(xfer_done)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Reference model: stage codes 0 idle,1 data OUT,2 data IN,3 status IN,4 status OUT,5 stall
    int m_stage = 0;
    int m_len   = 0;
    int m_cnt   = 0;
    bit m_ok    = 0;
    bit m_done  = 0;

    always @(posedge clk) begin
        bit was_ok;
        bit ti;
        bit to;
        m_done = 0;
        if (!rst_n || usb_reset) begin
            m_stage = 0; m_len = 0; m_cnt = 0; m_ok = 0;
        end else if (setup_evt) begin
            m_len = int'(setup_pkt[55:48]) + 256 * int'(setup_pkt[63:56]);
            m_cnt = 0;
            m_ok  = 0;
            if (m_len == 0)          m_stage = 3;
            else if (setup_pkt[7])   m_stage = 2;
            else                     m_stage = 1;
        end else if (m_stage >= 1 && m_stage <= 4 && dec_strobe && !dec_ok) begin
            m_stage = 5;
        end else begin
            was_ok = m_ok;
            if (m_stage >= 1 && m_stage <= 4 && dec_strobe && dec_ok) m_ok = 1;
            ti = tok_in;
            to = tok_out && !tok_in;
            if (m_stage == 1) begin
                if (ti) m_stage = 3;
                else if (to) begin
                    if (m_cnt + int'(tok_len) > m_len) m_stage = 5;
                    else m_cnt += int'(tok_len);
                end
            end else if (m_stage == 2) begin
                if (to) m_stage = 4;
                else if (ti) begin
                    if (m_cnt + int'(tok_len) > m_len) m_stage = 5;
                    else m_cnt += int'(tok_len);
                end
            end else if (m_stage == 3) begin
                if (to) m_stage = 5;
                else if (ti && was_ok) begin m_stage = 0; m_done = 1; end
            end else if (m_stage == 4) begin
                if (ti) m_stage = 5;
                else if (to && was_ok) begin m_stage = 0; m_done = 1; end
            end
        end
    end

    task automatic compare();
        int  e_stage = m_stage;
        bit  e_stall = (m_stage == 5);
        bit  e_stat  = (m_stage == 3 || m_stage == 4);
        bit  e_zlp   = (m_stage == 3) && m_ok;
        n_vec++;
        if (int'(stage) != e_stage || stall !== e_stall || status_phase !== e_stat ||
            zlp_req !== e_zlp || xfer_done !== m_done) begin
            n_fail++;
            $display("FAIL %s: stage/stall/stat/zlp/done actual %0d/%0b/%0b/%0b/%0b expected %0d/%0b/%0b/%0b/%0b",
                     cur_req, stage, stall, status_phase, zlp_req, xfer_done,
                     e_stage, e_stall, e_stat, e_zlp, m_done);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        usb_reset = 0; setup_evt = 0; tok_in = 0; tok_out = 0; dec_strobe = 0; dec_ok = 0;
    endtask

    task automatic do_setup(input bit to_host, input int wlen);
        setup_pkt = {wlen[15:8], wlen[7:0], 8'h00, 8'h00, 8'h5a, 8'h01, 8'h06,
                     to_host, 7'h00};
        setup_evt = 1;
        cycle();
    endtask

    task automatic do_in(input int len);
        tok_in = 1; tok_len = PLW'(len); cycle();
    endtask

    task automatic do_out(input int len);
        tok_out = 1; tok_len = PLW'(len); cycle();
    endtask

    task automatic do_dec(input bit ok);
        dec_strobe = 1; dec_ok = ok; cycle();
    endtask

    task automatic expect_stage(input int exp);
        n_vec++;
        if (int'(stage) != exp) begin
            n_fail++;
            $display("FAIL %s: stage actual %0d expected %0d", cur_req, stage, exp);
        end
    endtask

    initial begin
        repeat (3) cycle();
        cur_req = "R1";
        expect_stage(0);
        rst_n = 1;
        cycle();

        // R2 R4 R6 R7: OUT-direction transfer of 100 bytes
        cur_req = "R2";
        do_setup(0, 100); expect_stage(1);
        do_out(64); do_out(36);
        cur_req = "R6";
        do_dec(1);
        cur_req = "R4";
        do_in(0); expect_stage(3);
        cur_req = "R7";
        do_in(0); expect_stage(0);
        cycle();

        // R8 boundary: 272 bytes (high byte != low byte), land exactly on the limit
        cur_req = "R8";
        do_setup(1, 272); expect_stage(2);
        for (int i = 0; i < 4; i++) do_in(64);
        do_in(16); expect_stage(2);
        cur_req = "R5";
        do_dec(1);
        do_out(0); expect_stage(4);
        cur_req = "R7";
        do_out(0); expect_stage(0);

        // R3: zero length with IN direction bit; R7 token before acceptance
        cur_req = "R3";
        do_setup(1, 0); expect_stage(3);
        cur_req = "R7";
        do_in(0); expect_stage(3);
        do_dec(1); do_in(0); expect_stage(0);

        // R8 overrun then R11 stall stickiness, R12 exit
        cur_req = "R8";
        do_setup(0, 10); do_out(8); do_out(4); expect_stage(5);
        cur_req = "R11";
        do_in(0); do_out(3); do_dec(1); do_dec(0); expect_stage(5);
        cur_req = "R12";
        do_setup(1, 5); expect_stage(2);

        // R9: decoder reject
        cur_req = "R9";
        do_in(3); do_dec(0); expect_stage(5);

        // R10: data-direction token in status stage
        cur_req = "R10";
        do_setup(0, 8); do_in(0); do_out(0); expect_stage(5);
        do_setup(1, 8); do_out(0); do_in(2); expect_stage(5);

        // R12: SETUP mid-data restarts count
        cur_req = "R12";
        do_setup(0, 20); do_out(15); do_dec(1);
        do_setup(0, 20); do_out(20); expect_stage(1);
        do_in(0); expect_stage(3);

        // R1: bus reset mid transfer
        cur_req = "R1";
        usb_reset = 1; cycle(); expect_stage(0);

        // R13: priorities
        cur_req = "R13";
        do_in(4); do_out(4); do_dec(0); expect_stage(0);
        usb_reset = 1; setup_pkt = 64'h0010_0000_0000_0000; setup_evt = 1; cycle();
        expect_stage(0);
        dec_strobe = 1; dec_ok = 0; do_setup(0, 16); expect_stage(1);
        tok_out = 1; do_in(0); expect_stage(3);

        // random traffic
        cur_req = "R13";
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 6) begin
                setup_pkt = {8'($urandom_range(0,1)), 8'($urandom_range(0,150)),
                             32'h0, 8'h01, 8'h06, 8'($urandom_range(0,1) << 7)};
                setup_evt = 1;
            end
            if (r == 99) usb_reset = 1;
            if ($urandom_range(0, 9) < 3) tok_in = 1;
            if ($urandom_range(0, 9) < 3) tok_out = 1;
            tok_len = PLW'($urandom_range(0, 64));
            if ($urandom_range(0, 9) < 2) begin
                dec_strobe = 1;
                dec_ok = ($urandom_range(0, 9) != 0);
            end
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule